// File: doc/BRIEF.md
# Dual-source clock output divider

This block drives a bank of divided clock outputs, each built from one of two references: a 32768 Hz low-speed clock or a high-speed clock of roughly 4 MHz. Each reference reaches the block as a strobe in the system clock domain. The strobe is high for one system cycle at every edge of that reference, both rising and falling. All divider counters advance on the strobe of the selected source. Each output is a registered level that changes only on a strobe, so the divided clocks stay in phase with their references.

Each output has one 8-bit control register, and the registers sit at consecutive addresses. The enable is bit 0. The source select is bit 4. A 3-bit post-divider code in bits [3:1] divides by a power of two. A 3-bit pre-divider code in bits [7:5] applies only to the high-speed source. Its top code divides by 122, which is not a power of two, and it still keeps a 50% duty cycle. A written value waits in the register until the running output finishes a complete period, so no shortened pulse is ever emitted.

Top module: `clkout_bank`

## Requirements
- R1: While reset is asserted and directly after it, every register reads 0 and every output is low.
- R2: Registers live at addresses 0 to NUM_CH-1. A read, combinational on the read address, returns the last byte written there. A write to an address of NUM_CH or above changes nothing, and reading such an address returns 0.
- R3: While the applied configuration has bit 0 (enable) clear, the output is held low.
- R4: With bit 4 = 1, the high-speed strobe is used. A pre-divider code k of 0 to 6 in bits [7:5] divides by 2^k, so with bits [3:1] = 0 the output changes level every 2^k strobes.
- R5: Pre-divider code 7 divides by 122 with a 50% duty cycle. The high and low phases are each 122 strobes long, which is 61 reference cycles.
- R6: With bit 4 = 0, the low-speed strobe is used and the pre-divider code has no effect.
- R7: Post-divider code n in bits [3:1] divides by 2^n. The output changes level every D*2^n strobes of the selected source, where D is the pre-divider factor (1 on the low-speed source).
- R8: A written value takes effect at once if the applied configuration is disabled. Otherwise it takes effect only at the falling edge that ends the current high phase. The high phase already in progress keeps its old length, and the next low phase has the new length.
- R9: The outputs run independently, each at its own configured rate.
- R10: Clearing the enable lets the current period finish, and the output then stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hf_edge | input | 1 | Strobe at every edge of the high-speed reference |
| lf_edge | input | 1 | Strobe at every edge of the 32768 Hz reference |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 8 | Register read data |
| clk_out | output | NUM_CH | Divided clock outputs |

## Verification
The high-speed strobe is held high every cycle, so high and low phase lengths in system cycles equal the divide factor directly. Stepping through every pre-divider code exposes any mistake in the power-of-two table or in the special divide-by-122 limit. The low-speed strobe pulses every fourth cycle, which separates bypass (R6) from an applied pre-divider: identical phase lengths across pre codes on that source prove bypass. A mid-high-phase rewrite and a mid-period disable show whether changes wait for a period boundary. A nonzero high-phase length on one channel while the others run shows whether it truly runs independently.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  localparam int unsigned REG_W       = 8;
  localparam int unsigned PRE_CODE_W  = 3;
  localparam int unsigned POST_CODE_W = 3;

  // Field layout of one control byte, msb first.
  typedef struct packed {
    logic [PRE_CODE_W-1:0]  pre_code;
    logic                   src_hf;
    logic [POST_CODE_W-1:0] post_code;
    logic                   enable;
  } chan_cfg_t;
endpackage

// File: rtl/clkout_prediv.sv
module clkout_prediv #(
  parameter  int unsigned CODE_W   = 3,
  parameter  int unsigned TOP_DIV  = 122,
  localparam int unsigned CNT_W    = $clog2(TOP_DIV),
  localparam int unsigned TOP_CODE = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_tick,
  input  logic              bypass,
  input  logic              clear,
  input  logic [CODE_W-1:0] code,
  output logic              div_tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d, last;
  logic             wrap;

  // Top code divides by TOP_DIV, the others by 2^code.
  always_comb begin
    if (code == CODE_W'(TOP_CODE)) last = CNT_W'(TOP_DIV - 1);
    else                           last = CNT_W'((32'd1 << code) - 32'd1);
  end

  assign wrap     = (cnt_q == last);
  assign div_tick = bypass ? src_tick : (src_tick && wrap);

  always_comb begin
    cnt_d = cnt_q;
    if (clear || bypass)  cnt_d = '0;
    else if (src_tick)    cnt_d = wrap ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/clkout_postdiv.sv
module clkout_postdiv #(
  parameter  int unsigned CODE_W = 3,
  localparam int unsigned CNT_W  = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_tick,
  input  logic              clear,
  input  logic [CODE_W-1:0] code,
  output logic              level,
  output logic              period_end
);
  logic [CNT_W-1:0] cnt_q, cnt_d, last;
  logic             level_q, level_d;
  logic             term;

  // 2^code - 1; the top code wraps to all ones, which is exact.
  assign last       = (CNT_W'(1) << code) - CNT_W'(1);
  assign term       = in_tick && (cnt_q == last);
  assign period_end = term && level_q;
  assign level      = level_q;

  always_comb begin
    cnt_d   = cnt_q;
    level_d = level_q;
    if (clear) begin
      cnt_d   = '0;
      level_d = 1'b0;
    end else if (in_tick) begin
      cnt_d = term ? '0 : cnt_q + CNT_W'(1);
      if (term) level_d = ~level_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      level_q <= level_d;
    end
  end
endmodule

// File: rtl/clkout_channel.sv
module clkout_channel
  import clkout_pkg::*;
#(
  parameter int unsigned TOP_DIV = 122
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hf_tick,
  input  logic      lf_tick,
  input  logic      wr_stb,
  input  chan_cfg_t wr_cfg,
  output chan_cfg_t cfg_o,
  output chan_cfg_t act_o,
  output logic      level_o
);
  chan_cfg_t cfg_q, cfg_d, act_q, act_d;
  logic      apply, period_end, src_tick, pre_tick;

  // Staged settings move into the running set only between periods.
  assign apply    = !act_q.enable || period_end;
  assign src_tick = act_q.src_hf ? hf_tick : lf_tick;

  always_comb begin
    cfg_d = cfg_q;
    act_d = act_q;
    if (wr_stb) cfg_d = wr_cfg;
    if (apply)  act_d = cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      act_q <= '0;
    end else begin
      cfg_q <= cfg_d;
      act_q <= act_d;
    end
  end

  clkout_prediv #(.CODE_W(PRE_CODE_W), .TOP_DIV(TOP_DIV)) pre_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_tick (src_tick),
    .bypass   (!act_q.src_hf),
    .clear    (apply),
    .code     (act_q.pre_code),
    .div_tick (pre_tick)
  );

  clkout_postdiv #(.CODE_W(POST_CODE_W)) post_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_tick    (pre_tick),
    .clear      (apply),
    .code       (act_q.post_code),
    .level      (level_o),
    .period_end (period_end)
  );

  assign cfg_o = cfg_q;
  assign act_o = act_q;
endmodule

// File: rtl/clkout_bank.sv
module clkout_bank
  import clkout_pkg::*;
#(
  parameter  int unsigned NUM_CH  = 3,
  parameter  int unsigned TOP_DIV = 122,
  localparam int unsigned ADDR_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hf_edge,
  input  logic              lf_edge,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic [NUM_CH-1:0] clk_out
);
  logic [1:0]                   rst_pipe_q;
  logic                         rst_sync_n;
  logic [NUM_CH-1:0][REG_W-1:0] cfg_vec;
  logic [NUM_CH-1:0][REG_W-1:0] act_vec;

  // Assert at once, release two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    chan_cfg_t cfg_w, act_w;
    logic      stb;
    assign stb = wr_en && (wr_addr == ADDR_W'(g));
    clkout_channel #(.TOP_DIV(TOP_DIV)) ch_i (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .hf_tick (hf_edge),
      .lf_tick (lf_edge),
      .wr_stb  (stb),
      .wr_cfg  (chan_cfg_t'(wr_data)),
      .cfg_o   (cfg_w),
      .act_o   (act_w),
      .level_o (clk_out[g])
    );
    assign cfg_vec[g] = cfg_w;
    assign act_vec[g] = act_w;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = cfg_vec[i];
  end
endmodule

module clkout_bank_chk #(
  parameter  int unsigned NUM_CH = 3,
  localparam int unsigned ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   hf_edge,
  input logic                   lf_edge,
  input logic                   wr_en,
  input logic [ADDR_W-1:0]      wr_addr,
  input logic [7:0]             wr_data,
  input logic [NUM_CH-1:0]      clk_out,
  input logic [NUM_CH-1:0][7:0] cfg_vec,
  input logic [NUM_CH-1:0][7:0] act_vec
);
  // R2: a write outside the bank leaves every register alone
  a_r2_miss_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (32'(wr_addr) >= NUM_CH)) |=> $stable(cfg_vec));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R2: a write reaches its own register on the next cycle
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(g)) |=> cfg_vec[g] == $past(wr_data));
    // R3: a disabled running configuration gives a low output
    a_r3_off_is_low: assert property (@(posedge clk) disable iff (!rst_n)
      !act_vec[g][0] |-> !clk_out[g]);
    // R8: the running configuration only ever changes while the output is low
    a_r8_swap_when_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_vec[g]) |-> !clk_out[g]);
    // R6: the output moves only on a strobe of the selected source
    a_r6_edge_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(clk_out[g]) |-> $past(act_vec[g][4] ? hf_edge : lf_edge));
  end
endmodule

bind clkout_bank clkout_bank_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .hf_edge (hf_edge),
  .lf_edge (lf_edge),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .clk_out (clk_out),
  .cfg_vec (cfg_vec),
  .act_vec (act_vec)
);

// File: tb/clkout_bank_tb_top.sv
module clkout_bank_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hf_edge = 1'b1;
  logic       lf_edge = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [2:0] clk_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int lf_cnt = 0;
  bit done = 0;

  clkout_bank dut_i (
    .clk(clk), .rst_n(rst_n), .hf_edge(hf_edge), .lf_edge(lf_edge),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .clk_out(clk_out)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  // Low-speed strobe: one pulse every fourth system cycle.
  always @(negedge clk) begin
    lf_cnt  <= (lf_cnt + 1) % 4;
    lf_edge <= (lf_cnt == 3);
  end

  function automatic logic [7:0] mk(int pre, int hf, int post, int en);
    return {pre[2:0], hf[0], post[2:0], en[0]};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(int a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_reg(int a, output int v);
    @(negedge clk);
    rd_addr = a[1:0];
    #1 v = int'(rd_data);
  endtask

  task automatic wait_level(int ch, bit lvl, output int t);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (clk_out[ch] != lvl && n < 40000);
    if (clk_out[ch] != lvl) chk(0, "timeout waiting for level", n, 0);
    t = cyc;
  endtask

  task automatic measure(int ch, output int hi, output int lo);
    int t0, r, f, r2;
    wait_level(ch, 0, t0);
    wait_level(ch, 1, r);
    wait_level(ch, 0, f);
    wait_level(ch, 1, r2);
    hi = f - r;
    lo = r2 - f;
  endtask

  task automatic count_high(int ch, int cycles, output int highs);
    highs = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (clk_out[ch]) highs++;
    end
  endtask

  task automatic div_case(int ch, logic [7:0] cfg, int exp, string tag);
    int hi, lo;
    wr_reg(ch, cfg);
    measure(ch, hi, lo);
    measure(ch, hi, lo);
    chk(hi == exp, {tag, " high phase"}, hi, exp);
    chk(lo == exp, {tag, " low phase"}, lo, exp);
  endtask

  task automatic t_reset();
    int v;
    for (int a = 0; a < 3; a++) begin
      rd_reg(a, v);
      chk(v == 0, "R1 register during reset", v, 0);
    end
    chk(clk_out == 3'b000, "R1 outputs during reset", int'(clk_out), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int a = 0; a < 3; a++) begin
      rd_reg(a, v);
      chk(v == 0, "R1 register after reset", v, 0);
    end
    chk(clk_out == 3'b000, "R1 outputs after reset", int'(clk_out), 0);
  endtask

  task automatic t_regs();
    logic [7:0] vals [3];
    int v;
    vals[0] = 8'hA4; vals[1] = 8'h3C; vals[2] = 8'hE8;   // all with bit 0 clear
    for (int a = 0; a < 3; a++) wr_reg(a, vals[a]);
    for (int a = 0; a < 3; a++) begin
      rd_reg(a, v);
      chk(v == int'(vals[a]), "R2 readback", v, int'(vals[a]));
    end
    wr_reg(3, 8'hFF);
    rd_reg(3, v);
    chk(v == 0, "R2 unmapped address reads zero", v, 0);
    for (int a = 0; a < 3; a++) begin
      rd_reg(a, v);
      chk(v == int'(vals[a]), "R2 unmapped write ignored", v, int'(vals[a]));
    end
  endtask

  task automatic t_disabled();
    int h;
    count_high(0, 100, h);
    chk(h == 0, "R3 ch0 disabled stays low", h, 0);
    count_high(1, 100, h);
    chk(h == 0, "R3 ch1 disabled stays low", h, 0);
  endtask

  task automatic t_pre_pow2();
    for (int k = 0; k < 7; k++) div_case(0, mk(k, 1, 0, 1), 1 << k, "R4 pre code");
  endtask

  task automatic t_pre_top();
    div_case(0, mk(7, 1, 0, 1), 122, "R5 divide by 122");
    div_case(0, mk(7, 1, 1, 1), 244, "R5 divide by 122 then 2");
  endtask

  task automatic t_lf_bypass();
    div_case(1, mk(0, 0, 1, 1), 8, "R6 low-speed code 0");
    div_case(1, mk(5, 0, 1, 1), 8, "R6 low-speed pre code ignored");
    div_case(1, mk(7, 0, 0, 1), 4, "R6 low-speed top code ignored");
  endtask

  task automatic t_post();
    for (int n = 0; n < 4; n++) div_case(2, mk(1, 1, n, 1), 2 << n, "R7 post code");
    div_case(2, mk(0, 1, 7, 1), 128, "R7 post code 7");
  endtask

  task automatic t_independent();
    int hi, lo;
    wr_reg(0, mk(0, 1, 1, 1));
    wr_reg(1, mk(0, 1, 2, 1));
    wr_reg(2, mk(0, 1, 3, 1));
    for (int ch = 0; ch < 3; ch++) begin
      measure(ch, hi, lo);
      measure(ch, hi, lo);
      chk(hi == (2 << ch) && lo == (2 << ch), "R9 channel rate", hi, 2 << ch);
    end
  endtask

  task automatic t_change_boundary();
    int t0, r, f, r2, hi, lo;
    div_case(0, mk(3, 1, 2, 1), 32, "R8 start rate");
    wait_level(0, 0, t0);
    wait_level(0, 1, r);
    wr_reg(0, mk(0, 1, 0, 1));
    wait_level(0, 0, f);
    chk(f - r == 32, "R8 in-flight high phase kept", f - r, 32);
    wait_level(0, 1, r2);
    chk(r2 - f == 1, "R8 next low phase uses new rate", r2 - f, 1);
    measure(0, hi, lo);
    chk(hi == 1 && lo == 1, "R8 new rate settled", hi, 1);
  endtask

  task automatic t_disable_mid();
    int t0, r, f, h, v;
    div_case(1, mk(4, 1, 0, 1), 16, "R10 start rate");
    wait_level(1, 0, t0);
    wait_level(1, 1, r);
    wr_reg(1, mk(4, 1, 0, 0));
    wait_level(1, 0, f);
    chk(f - r == 16, "R10 period completes before stop", f - r, 16);
    count_high(1, 300, h);
    chk(h == 0, "R10 stays low after disable", h, 0);
    rd_reg(1, v);
    chk(v == int'(mk(4, 1, 0, 0)), "R2 readback after disable", v, int'(mk(4, 1, 0, 0)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_regs();
    t_disabled();
    t_pre_pow2();
    t_pre_top();
    t_lf_bypass();
    t_post();
    t_independent();
    t_change_boundary();
    t_disable_mid();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule